// File: doc/BRIEF.md
# Write-Back Write-Allocate Data Cache

This block sits between a processor's load/store port and a word-wide memory master. It is direct-mapped: a request address splits into a tag, a set index and a byte offset within the line. The line length is fixed when the block is built and may be one, four or eight 32-bit words (4, 16 or 32 bytes). Every set has a valid bit, a dirty bit, a stored tag and its line of data words.

A load or store that hits finishes in the cycle it is presented, with no wait. A store hit writes only the cache and marks the line dirty. On any miss the controller first writes a dirty victim line back to memory, one word per accepted transfer. It then reads the requested line, one word per accepted transfer, and marks it valid and clean. It finishes in a completion cycle: a load returns its word there, and a store merges its bytes there and marks the line dirty. The processor holds its request steady until the block raises `cpu_ready`.

Top module: `dcache_wbwa`

## Requirements
- R1: A request address splits as word select = addr[OFF-1:2], set index = the next log2(SETS) bits above that, and tag = the remaining upper bits, where OFF = log2(line bytes). A load whose set is valid with a matching tag raises `cpu_ready` in the same cycle as `cpu_req` and returns the stored word.
- R2: A refill reads every word of the line in ascending word order from word 0. Each read uses the next word address (+4) and advances by one word for each cycle in which `mem_req` and `mem_ready` are both high.
- R3: A store hit changes the cache only. It issues no memory transfer, and the memory word stays unchanged until that line is evicted.
- R4: A store hit sets the line's dirty bit. A refill leaves the line valid and clean.
- R5: A miss to a valid, dirty set writes all words of the victim line to memory, to addresses formed from the victim's tag and the set index, before the first refill read.
- R6: A miss to an invalid or clean set issues no memory write.
- R7: A store miss refills the line, then merges the store data into the addressed word and marks the line dirty, so a later eviction writes the merged data back.
- R8: On a store, byte enable bit i (0 to 3) writes only data bits 8i+7 to 8i of the addressed word. This applies both on a hit and on the merge after a refill.
- R9: On a miss, `cpu_ready` stays low through write-back and refill. A load miss returns its word only in the cycle after the last refill read.
- R10: After reset every set is invalid, and while no request is present `cpu_ready` and `mem_req` are low.
- R11: While `mem_req` is high and `mem_ready` is low, `mem_req`, `mem_we` and `mem_addr` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until accepted |
| cpu_we | input | 1 | 1 for store, 0 for load |
| cpu_addr | input | ADDR_W | Byte address of the word |
| cpu_be | input | 4 | Store byte enables |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid while `cpu_ready` is high on a load |
| cpu_ready | output | 1 | Request completes at this clock edge |
| mem_req | output | 1 | Memory transfer requested |
| mem_we | output | 1 | 1 for write-back, 0 for refill read |
| mem_addr | output | ADDR_W | Word-aligned memory byte address |
| mem_wdata | output | 32 | Write-back data |
| mem_rdata | input | 32 | Refill data, valid when `mem_ready` is high |
| mem_ready | input | 1 | Memory accepts the transfer this cycle |

## Verification
The assertions assume that the processor holds `cpu_req`, `cpu_we`, `cpu_addr`, `cpu_be` and `cpu_wdata` stable from request until `cpu_ready`. They also assume that the memory returns read data in the same cycle it raises `mem_ready`. The bench drives requests at the falling edge and releases them only after it sees `cpu_ready` at the following rising edge. Its memory model answers reads from a word array without delay. One scenario toggles `mem_ready` every cycle, so transfers wait while their address and direction must stay fixed.

// File: rtl/dcache_pkg.sv
package dcache_pkg;
   typedef enum logic [1:0] {
      ST_LOOKUP = 2'd0,
      ST_WRBACK = 2'd1,
      ST_FILL   = 2'd2,
      ST_DONE   = 2'd3
   } cstate_e;
endpackage

// File: rtl/dcache_tags.sv
module dcache_tags #(
   parameter int SETS  = 16,
   parameter int TAG_W = 24,
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_valid,
   output logic             rd_dirty,
   output logic [TAG_W-1:0] rd_tag,
   input  logic             fill_we,
   input  logic [TAG_W-1:0] fill_tag,
   input  logic             dirty_set
);
   logic [SETS-1:0]  valid_q;
   logic [SETS-1:0]  dirty_q;
   logic [TAG_W-1:0] tag_q [SETS];

   assign rd_valid = valid_q[rd_idx];
   assign rd_dirty = dirty_q[rd_idx];
   assign rd_tag   = tag_q[rd_idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         dirty_q <= '0;
      end else begin
         if (fill_we) begin
            valid_q[rd_idx] <= 1'b1;
            dirty_q[rd_idx] <= 1'b0;
         end else if (dirty_set) begin
            dirty_q[rd_idx] <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (fill_we) tag_q[rd_idx] <= fill_tag;
   end

   AST_FILL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      fill_we |=> (valid_q[$past(rd_idx)] && !dirty_q[$past(rd_idx)])); // R4
   AST_ONE_TAG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !(fill_we && dirty_set)); // R7
endmodule

// File: rtl/dcache_data.sv
module dcache_data #(
   parameter int SETS   = 16,
   parameter int WORDS  = 4,
   parameter int IDX_W  = 4,
   parameter int BEAT_W = 2
) (
   input  logic              clk,
   input  logic [IDX_W-1:0]  idx,
   input  logic [BEAT_W-1:0] rd_word,
   output logic [31:0]       rd_data,
   input  logic              we,
   input  logic [BEAT_W-1:0] wr_word,
   input  logic [3:0]        be,
   input  logic [31:0]       wdata
);
   localparam int DEPTH  = SETS * WORDS;
   localparam int FLAT_W = $clog2(DEPTH);

   logic [31:0]       mem_q [DEPTH];
   logic [FLAT_W-1:0] rd_flat;
   logic [FLAT_W-1:0] wr_flat;

   generate
      if (WORDS == 1) begin : g_single
         assign rd_flat = idx;
         assign wr_flat = idx;
      end else begin : g_multi
         assign rd_flat = {idx, rd_word};
         assign wr_flat = {idx, wr_word};
      end
   endgenerate

   assign rd_data = mem_q[rd_flat];

   always_ff @(posedge clk) begin
      if (we) begin
         for (int b = 0; b < 4; b++) begin
            if (be[b]) mem_q[wr_flat][8*b +: 8] <= wdata[8*b +: 8];
         end
      end
   end

   AST_WRITE_ENABLES: assert property (@(posedge clk)
      we |-> (be != 4'b0000)); // R8
endmodule

// File: rtl/dcache_ctrl.sv
module dcache_ctrl
   import dcache_pkg::*;
#(
   parameter int WORDS  = 4,
   parameter int BEAT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic              hit,
   input  logic              victim_dirty,
   input  logic              mem_ready,
   output cstate_e           state,
   output logic [BEAT_W-1:0] beat,
   output logic              last_beat,
   output logic              cpu_ready,
   output logic              mem_req,
   output logic              mem_we,
   output logic              tag_fill,
   output logic              data_we,
   output logic              from_mem,
   output logic              dirty_set
);
   cstate_e           state_q, state_d;
   logic [BEAT_W-1:0] beat_q, beat_d;
   logic              xfer;
   logic              hit_now;

   assign state     = state_q;
   assign beat      = beat_q;
   assign last_beat = (beat_q == BEAT_W'(WORDS - 1));
   assign mem_req   = (state_q == ST_WRBACK) || (state_q == ST_FILL);
   assign mem_we    = (state_q == ST_WRBACK);
   assign xfer      = mem_req && mem_ready;
   assign hit_now   = (state_q == ST_LOOKUP) && cpu_req && hit;
   assign cpu_ready = hit_now || (state_q == ST_DONE);
   assign from_mem  = (state_q == ST_FILL);
   assign tag_fill  = from_mem && xfer && last_beat;
   assign dirty_set = cpu_we && (hit_now || (state_q == ST_DONE));
   assign data_we   = dirty_set || (from_mem && xfer);

   always_comb begin
      state_d = state_q;
      beat_d  = beat_q;
      unique case (state_q)
         ST_LOOKUP: begin
            beat_d = '0;
            if (cpu_req && !hit) state_d = victim_dirty ? ST_WRBACK : ST_FILL;
         end
         ST_WRBACK: if (xfer) begin
            beat_d = last_beat ? '0 : beat_q + 1'b1;
            if (last_beat) state_d = ST_FILL;
         end
         ST_FILL: if (xfer) begin
            beat_d = last_beat ? '0 : beat_q + 1'b1;
            if (last_beat) state_d = ST_DONE;
         end
         ST_DONE: state_d = ST_LOOKUP;
         default: state_d = ST_LOOKUP;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_LOOKUP;
         beat_q  <= '0;
      end else begin
         state_q <= state_d;
         beat_q  <= beat_d;
      end
   end

   AST_DONE_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DONE) |-> ($past(state_q) == ST_FILL)); // R9
   AST_WB_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_FILL && $past(state_q) == ST_WRBACK) |-> $past(last_beat && mem_ready)); // R5
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_req |-> !cpu_ready || (state_q == ST_DONE)); // R10
endmodule

// File: rtl/dcache_wbwa.sv
module dcache_wbwa
   import dcache_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 16,
   parameter int SETS       = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [3:0]        cpu_be,
   input  logic [31:0]       cpu_wdata,
   output logic [31:0]       cpu_rdata,
   output logic              cpu_ready,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic [31:0]       mem_rdata,
   input  logic              mem_ready
);
   localparam int WORDS  = LINE_BYTES / 4;
   localparam int OFF_W  = $clog2(LINE_BYTES);
   localparam int BEAT_W = (WORDS > 1) ? $clog2(WORDS) : 1;
   localparam int IDX_W  = $clog2(SETS);
   localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;

   generate
      if (!(LINE_BYTES == 4 || LINE_BYTES == 16 || LINE_BYTES == 32)) begin : g_bad_line
         $error("LINE_BYTES must be 4, 16 or 32");
      end
      if (SETS < 2 || (1 << IDX_W) != SETS) begin : g_bad_sets
         $error("SETS must be a power of two of at least 2");
      end
      if (TAG_W < 1) begin : g_bad_addr
         $error("ADDR_W too small for the cache geometry");
      end
   endgenerate

   cstate_e           state;
   logic [BEAT_W-1:0] beat;
   logic              last_beat;
   logic [IDX_W-1:0]  req_idx;
   logic [TAG_W-1:0]  req_tag;
   logic [BEAT_W-1:0] req_word;
   logic              set_valid, set_dirty;
   logic [TAG_W-1:0]  set_tag;
   logic              hit;
   logic              tag_fill, data_we, from_mem, dirty_set;
   logic [31:0]       rd_data;
   logic [TAG_W-1:0]  line_tag;

   assign req_idx = cpu_addr[OFF_W +: IDX_W];
   assign req_tag = cpu_addr[ADDR_W-1 -: TAG_W];

   generate
      if (WORDS == 1) begin : g_word1
         assign req_word = '0;
         assign mem_addr = {line_tag, req_idx, 2'b00};
      end else begin : g_wordn
         assign req_word = cpu_addr[OFF_W-1:2];
         assign mem_addr = {line_tag, req_idx, beat, 2'b00};
      end
   endgenerate

   assign hit       = set_valid && (set_tag == req_tag);
   assign line_tag  = (state == ST_WRBACK) ? set_tag : req_tag;
   assign mem_wdata = rd_data;
   assign cpu_rdata = rd_data;

   dcache_ctrl #(.WORDS(WORDS), .BEAT_W(BEAT_W)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .cpu_req      (cpu_req),
      .cpu_we       (cpu_we),
      .hit          (hit),
      .victim_dirty (set_valid && set_dirty),
      .mem_ready    (mem_ready),
      .state        (state),
      .beat         (beat),
      .last_beat    (last_beat),
      .cpu_ready    (cpu_ready),
      .mem_req      (mem_req),
      .mem_we       (mem_we),
      .tag_fill     (tag_fill),
      .data_we      (data_we),
      .from_mem     (from_mem),
      .dirty_set    (dirty_set)
   );

   dcache_tags #(.SETS(SETS), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_idx    (req_idx),
      .rd_valid  (set_valid),
      .rd_dirty  (set_dirty),
      .rd_tag    (set_tag),
      .fill_we   (tag_fill),
      .fill_tag  (req_tag),
      .dirty_set (dirty_set)
   );

   dcache_data #(.SETS(SETS), .WORDS(WORDS), .IDX_W(IDX_W), .BEAT_W(BEAT_W)) u_data (
      .clk     (clk),
      .idx     (req_idx),
      .rd_word ((state == ST_WRBACK) ? beat : req_word),
      .rd_data (rd_data),
      .we      (data_we),
      .wr_word (from_mem ? beat : req_word),
      .be      (from_mem ? 4'hF : cpu_be),
      .wdata   (from_mem ? mem_rdata : cpu_wdata)
   );

   AST_HOLD_XFER: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R11
   AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ready && !last_beat) |=> (mem_req && mem_addr == $past(mem_addr) + ADDR_W'(4))); // R2
   AST_HIT_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && cpu_ready && !$past(mem_req)) |-> !mem_req); // R3
endmodule

// File: tb/sim_dcache_wbwa.sv
module sim_dcache_wbwa;
   localparam int AW = 32;
   localparam int WORDS = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_req = 1'b0, cpu_we = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic [3:0]    cpu_be = 4'h0;
   logic [31:0]   cpu_wdata = '0;
   logic [31:0]   cpu_rdata;
   logic          cpu_ready;
   logic          mem_req, mem_we, mem_ready;
   logic [AW-1:0] mem_addr;
   logic [31:0]   mem_wdata, mem_rdata;

   logic [31:0] bmem  [0:1023];
   logic [31:0] shadow [0:1023];
   int n_chk = 0, n_bad = 0;
   int rd_cnt = 0, wr_cnt = 0;
   bit seen_rd = 1'b0, order_bad = 1'b0;
   bit throttle = 1'b0;
   bit tgl = 1'b0;

   always #2 clk = ~clk;

   dcache_wbwa #(.ADDR_W(AW), .LINE_BYTES(16), .SETS(16)) u0 (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
      .cpu_addr(cpu_addr), .cpu_be(cpu_be), .cpu_wdata(cpu_wdata),
      .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_ready(mem_ready)
   );

   assign mem_rdata = bmem[mem_addr[11:2]];
   assign mem_ready = throttle ? tgl : 1'b1;

   always @(posedge clk) begin
      tgl <= ~tgl;
      if (mem_req && mem_ready) begin
         if (mem_we) begin
            bmem[mem_addr[11:2]] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
            if (seen_rd) order_bad <= 1'b1;
         end else begin
            rd_cnt <= rd_cnt + 1;
            seen_rd <= 1'b1;
         end
      end
   end

   function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] nw, logic [3:0] be);
      logic [31:0] r = old;
      for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = nw[8*b +: 8];
      return r;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic clr_counts();
      @(negedge clk);
      rd_cnt = 0; wr_cnt = 0; seen_rd = 1'b0; order_bad = 1'b0;
   endtask

   task automatic access(input bit we, input logic [AW-1:0] a, input logic [3:0] be,
                         input logic [31:0] wd, output logic [31:0] rd, output int waits);
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_be = be; cpu_wdata = wd;
      waits = 0;
      forever begin
         #1;
         if (cpu_ready) begin
            rd = cpu_rdata;
            @(posedge clk);
            break;
         end
         @(negedge clk);
         waits++;
      end
      if (we) shadow[a[11:2]] = merge(shadow[a[11:2]], wd, be);
      @(negedge clk);
      cpu_req = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] d; int w;
      chk("R10 ready low after reset", {31'd0, cpu_ready}, 32'd0);
      chk("R10 mem_req low after reset", {31'd0, mem_req}, 32'd0);
      clr_counts();
      access(1'b0, 32'h40, 4'h0, 0, d, w);
      chk("R10 first load misses", rd_cnt, WORDS);
      chk("R2 refill data word 0", d, shadow[32'h40 >> 2]);
      chk("R6 no write on invalid set", wr_cnt, 0);
      chk("R9 load miss stalls", {31'd0, w >= WORDS}, 32'd1);
   endtask

   task automatic t_hits();
      logic [31:0] d; int w;
      clr_counts();
      access(1'b0, 32'h44, 4'h0, 0, d, w);
      chk("R1 load hit data", d, shadow[32'h44 >> 2]);
      chk("R1 load hit no wait", w, 0);
      access(1'b1, 32'h44, 4'b0011, 32'hDEADBEEF, d, w);
      chk("R3 store hit no wait", w, 0);
      access(1'b0, 32'h44, 4'h0, 0, d, w);
      chk("R8 hit merge low bytes", d, merge(bmem[32'h44 >> 2], 32'hDEADBEEF, 4'b0011));
      chk("R3 no memory traffic", rd_cnt + wr_cnt, 0);
      chk("R3 memory untouched", bmem[32'h44 >> 2], 32'h1000_0000 + 17 * 32'h0001_0203);
   endtask

   task automatic t_evict_dirty();
      logic [31:0] d; int w;
      clr_counts();
      access(1'b0, 32'h140, 4'h0, 0, d, w);
      chk("R5 victim words written", wr_cnt, WORDS);
      chk("R5 writes precede reads", {31'd0, order_bad}, 32'd0);
      chk("R2 refill read count", rd_cnt, WORDS);
      chk("R9 load after eviction", d, shadow[32'h140 >> 2]);
      for (int i = 0; i < WORDS; i++)
         chk("R4 written-back word", bmem[(32'h40 >> 2) + i], shadow[(32'h40 >> 2) + i]);
   endtask

   task automatic t_store_miss();
      logic [31:0] d; int w;
      clr_counts();
      access(1'b1, 32'h288, 4'b1100, 32'hCAFE1234, d, w);
      chk("R6 clean set no write", wr_cnt, 0);
      chk("R7 store miss refills", rd_cnt, WORDS);
      access(1'b0, 32'h288, 4'h0, 0, d, w);
      chk("R7 merged word hit", d, shadow[32'h288 >> 2]);
      chk("R8 merge high bytes only", d, merge(32'h1000_0000 + 162 * 32'h0001_0203, 32'hCAFE1234, 4'b1100));
      chk("R7 merged hit no wait", w, 0);
      clr_counts();
      access(1'b0, 32'h388, 4'h0, 0, d, w);
      chk("R7 merged line dirty", wr_cnt, WORDS);
      chk("R7 merged data in memory", bmem[32'h288 >> 2], shadow[32'h288 >> 2]);
   endtask

   task automatic t_throttle();
      logic [31:0] d; int w;
      throttle = 1'b1;
      clr_counts();
      access(1'b0, 32'h50C, 4'h0, 0, d, w);
      chk("R11 throttled load data", d, shadow[32'h50C >> 2]);
      chk("R11 throttled read count", rd_cnt, WORDS);
      throttle = 1'b0;
      clr_counts();
      access(1'b0, 32'h600, 4'h0, 0, d, w);
      chk("R6 clean victim skipped", wr_cnt, 0);
      chk("R2 clean replace data", d, shadow[32'h600 >> 2]);
   endtask

   initial begin
      for (int i = 0; i < 1024; i++) begin
         bmem[i] = 32'h1000_0000 + i * 32'h0001_0203;
         shadow[i] = bmem[i];
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_hits();
      t_evict_dirty();
      t_store_miss();
      t_throttle();
      repeat (2) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule